// File: doc/BRIEF.md
# Voice Interrupt Source Queue

This block collects per-voice interrupt requests from a bank of synthesizer voices and hands them to the host one at a time. There are two event classes: wavetable events (a voice reached its loop point or end) and volume-ramp events (a voice's volume ramp finished). Each voice has one pending bit per class. A one-cycle pulse on a voice's event input sets that bit.

The host dequeues an event by writing the interrupt-source function code 0x8F to the function-select register. On that write the block picks one pending event. Every wavetable event is served before any volume-ramp event, and within a class the lowest voice number goes first. The block clears the chosen bit and latches a status byte that describes the event, which the host then reads back. Alongside the status byte it emits a one-cycle request to clear bit 7 of the served voice's wave-control or ramp-control register. It also inserts the two class summary bits into the global IRQ status byte and raises the IRQ line while that byte is non-zero.

Top module: `voice_irq_queue`

## Requirements
- R1: After the synchronous reset `rst`, `src_status` is 0xE8, both summary bits (bits 5 and 6 of `irq_status`) are 0, and both clear pulses are low.
- R2: A dequeue happens only in a cycle with `fsel_wr` high and `fsel_data` equal to 0x8F. A write of any other code, or no write, leaves `src_status` and the pending sets unchanged.
- R3: On a dequeue, a pending wavetable event is always chosen before any volume-ramp event.
- R4: Within the chosen class, the lowest-numbered pending voice (0 to NUM_VOICES-1) is served.
- R5: The status byte after a dequeue is {3'b011, voice} for a wavetable event, {3'b100, voice} for a ramp event, and 0xE8 when nothing is pending. A 0 in bit 7 marks a wavetable event and a 0 in bit 6 marks a ramp event.
- R6: In the cycle after a dequeue that served an event, `voice_clr_wave` (wavetable) or `voice_clr_ramp` (ramp) is high for one cycle, with `voice_clr_idx` set to the served voice. The two pulses are never high together.
- R7: Bit 5 of `irq_status` is 1 exactly while any wavetable bit is pending. Bit 6 is 1 exactly while any ramp bit is pending.
- R8: The other bits of `irq_status` follow `irq_other`. `irq_line` is 1 exactly when `irq_status` is non-zero.
- R9: While `soft_reset` is high, both pending sets are cleared on the clock edge, and this overrides event pulses in the same cycle.
- R10: An event pulse in the same cycle as a dequeue of that same bit keeps the bit pending.
- R11: Each dequeue removes exactly one event. N pending events need N dequeues before the status reads 0xE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_reset | input | 1 | Chip-level reset request; clears both pending sets |
| wave_evt | input | NUM_VOICES | Wavetable event pulses, one per voice |
| ramp_evt | input | NUM_VOICES | Volume-ramp event pulses, one per voice |
| fsel_wr | input | 1 | Write strobe for the function-select register |
| fsel_data | input | 8 | Function code being written |
| irq_other | input | 8 | Global IRQ status bits owned by other sources (bits 5 and 6 ignored) |
| src_status | output | 8 | Latched interrupt-source status byte |
| voice_clr_wave | output | 1 | Pulse: clear bit 7 of the served voice's wave-control register |
| voice_clr_ramp | output | 1 | Pulse: clear bit 7 of the served voice's ramp-control register |
| voice_clr_idx | output | 5 | Voice addressed by the clear pulse |
| irq_status | output | 8 | Global IRQ status byte, including both summary bits |
| irq_line | output | 1 | IRQ request; high while `irq_status` is non-zero |

## Verification
The bench builds the block with the default 31 voices. This puts the top voice number 30 and a fully loaded set within reach, so the bench can drain all 31 wavetable events in order before any ramp event. Random sparse pulses are mixed with dequeues and with writes of other codes. Directed cases cover the exact-cycle collision of a pulse with the dequeue of the same bit and a chip reset that arrives with pulses. They also check the IRQ line with only external bits set.

// File: rtl/vq_pkg.sv
package vq_pkg;

    localparam int VOICE_BITS   = 5;
    localparam int STAT_W       = 8;
    localparam int WAVE_SUM_BIT = 5;
    localparam int RAMP_SUM_BIT = 6;

    localparam logic [STAT_W-1:0] FSEL_IRQ_SRC = 8'h8F;
    localparam logic [STAT_W-1:0] STAT_IDLE    = 8'hE8;
    localparam logic [2:0]        WAVE_TAG     = 3'b011;
    localparam logic [2:0]        RAMP_TAG     = 3'b100;

    typedef logic [VOICE_BITS-1:0] voice_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WAVE = 2'd1,
        SRC_RAMP = 2'd2
    } src_kind_e;

    typedef struct packed {
        src_kind_e kind;
        voice_t    voice;
    } pick_t;

    function automatic logic [STAT_W-1:0] encode_status(pick_t p);
        case (p.kind)
            SRC_WAVE: encode_status = {WAVE_TAG, p.voice};
            SRC_RAMP: encode_status = {RAMP_TAG, p.voice};
            default:  encode_status = STAT_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/vq_lowest_pick.sv
module vq_lowest_pick
    import vq_pkg::*;
#(
    parameter int N = 31
) (
    input  logic [N-1:0] req,
    output logic         any,
    output voice_t       idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = voice_t'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/vq_pending_set.sv
module vq_pending_set
    import vq_pkg::*;
#(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [N-1:0] set_vec,
    input  logic         clr_en,
    input  voice_t       clr_idx,
    output logic [N-1:0] pend
);
    logic [N-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (clr_en && (clr_idx == voice_t'(i))) clr_mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) pend <= '0;
        else              pend <= (pend & ~clr_mask) | set_vec;
    end
endmodule

// File: rtl/voice_irq_queue.sv
module voice_irq_queue
    import vq_pkg::*;
#(
    parameter int NUM_VOICES = 31
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_reset,
    input  logic [NUM_VOICES-1:0] wave_evt,
    input  logic [NUM_VOICES-1:0] ramp_evt,
    input  logic                  fsel_wr,
    input  logic [7:0]            fsel_data,
    input  logic [7:0]            irq_other,
    output logic [7:0]            src_status,
    output logic                  voice_clr_wave,
    output logic                  voice_clr_ramp,
    output logic [4:0]            voice_clr_idx,
    output logic [7:0]            irq_status,
    output logic                  irq_line
);
    localparam int NCLASS = 2;
    localparam logic [7:0] SUM_MASK = 8'((1 << WAVE_SUM_BIT) | (1 << RAMP_SUM_BIT));

    logic [NCLASS-1:0][NUM_VOICES-1:0] evt_vec;
    logic [NCLASS-1:0][NUM_VOICES-1:0] pend_vec;
    logic [NCLASS-1:0]                 has_any;
    voice_t                            cand [NCLASS];
    logic                              deq;
    pick_t                             pick;

    assign evt_vec[0] = wave_evt;
    assign evt_vec[1] = ramp_evt;
    assign deq        = fsel_wr && (fsel_data == FSEL_IRQ_SRC);

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        localparam src_kind_e KIND = (c == 0) ? SRC_WAVE : SRC_RAMP;

        vq_pending_set #(.N(NUM_VOICES)) u_set (
            .clk     (clk),
            .rst     (rst),
            .flush   (soft_reset),
            .set_vec (evt_vec[c]),
            .clr_en  (deq && (pick.kind == KIND)),
            .clr_idx (pick.voice),
            .pend    (pend_vec[c])
        );

        vq_lowest_pick #(.N(NUM_VOICES)) u_pick (
            .req (pend_vec[c]),
            .any (has_any[c]),
            .idx (cand[c])
        );
    end

    // class priority: wavetable set before ramp set
    always_comb begin
        if (has_any[0])      pick = '{kind: SRC_WAVE, voice: cand[0]};
        else if (has_any[1]) pick = '{kind: SRC_RAMP, voice: cand[1]};
        else                 pick = '{kind: SRC_NONE, voice: '0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_status     <= STAT_IDLE;
            voice_clr_wave <= 1'b0;
            voice_clr_ramp <= 1'b0;
            voice_clr_idx  <= '0;
        end else begin
            voice_clr_wave <= deq && (pick.kind == SRC_WAVE);
            voice_clr_ramp <= deq && (pick.kind == SRC_RAMP);
            if (deq) begin
                src_status    <= encode_status(pick);
                voice_clr_idx <= pick.voice;
            end
        end
    end

    always_comb begin
        irq_status               = irq_other & ~SUM_MASK;
        irq_status[WAVE_SUM_BIT] = has_any[0];
        irq_status[RAMP_SUM_BIT] = has_any[1];
    end

    assign irq_line = |irq_status;
endmodule

// File: rtl/voice_irq_queue_chk.sv
module voice_irq_queue_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_reset,
    input logic       fsel_wr,
    input logic [7:0] fsel_data,
    input logic [7:0] src_status,
    input logic       voice_clr_wave,
    input logic       voice_clr_ramp,
    input logic [4:0] voice_clr_idx,
    input logic [7:0] irq_status
);
    logic deq;
    assign deq = fsel_wr && (fsel_data == 8'h8F);

    a_r2_no_change_without_dequeue: assert property (@(posedge clk) disable iff (rst)
        !deq |=> $stable(src_status));

    a_r3_wave_first: assert property (@(posedge clk) disable iff (rst)
        (deq && irq_status[5]) |=> (src_status[7:5] == 3'b011) && voice_clr_wave);

    a_r6_clear_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(voice_clr_wave && voice_clr_ramp));

    a_r6_clear_matches_status: assert property (@(posedge clk) disable iff (rst)
        (voice_clr_wave || voice_clr_ramp) |-> (voice_clr_idx == src_status[4:0]));

    a_r5_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        (deq && !irq_status[5] && !irq_status[6]) |=> (src_status == 8'hE8) && !voice_clr_wave && !voice_clr_ramp);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> (irq_status[6:5] == 2'b00));
endmodule

bind voice_irq_queue voice_irq_queue_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .soft_reset     (soft_reset),
    .fsel_wr        (fsel_wr),
    .fsel_data      (fsel_data),
    .src_status     (src_status),
    .voice_clr_wave (voice_clr_wave),
    .voice_clr_ramp (voice_clr_ramp),
    .voice_clr_idx  (voice_clr_idx),
    .irq_status     (irq_status)
);

// File: tb/voice_irq_queue_tb.sv
module voice_irq_queue_tb;
    localparam int NV = 31;

    logic          clk = 1'b0;
    logic          rst, soft_reset, fsel_wr;
    logic [NV-1:0] wave_evt, ramp_evt;
    logic [7:0]    fsel_data, irq_other;
    logic [7:0]    src_status, irq_status;
    logic          voice_clr_wave, voice_clr_ramp, irq_line;
    logic [4:0]    voice_clr_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model
    logic [NV-1:0] m_wave = '0, m_ramp = '0;
    logic [7:0]    m_stat = 8'hE8;
    logic          m_cw = 0, m_cr = 0;
    logic [4:0]    m_idx = '0;

    always #4 clk = ~clk;

    voice_irq_queue #(.NUM_VOICES(NV)) u_dut (
        .clk(clk), .rst(rst), .soft_reset(soft_reset),
        .wave_evt(wave_evt), .ramp_evt(ramp_evt),
        .fsel_wr(fsel_wr), .fsel_data(fsel_data), .irq_other(irq_other),
        .src_status(src_status), .voice_clr_wave(voice_clr_wave),
        .voice_clr_ramp(voice_clr_ramp), .voice_clr_idx(voice_clr_idx),
        .irq_status(irq_status), .irq_line(irq_line)
    );

    function automatic int lowest(logic [NV-1:0] v);
        for (int i = 0; i < NV; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_irq(logic [7:0] oth, logic [NV-1:0] w, logic [NV-1:0] r);
        logic [7:0] s;
        s = oth & 8'h9F;
        s[5] = |w;
        s[6] = |r;
        return s;
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // one clock: drive, advance the model across the edge, check after the edge
    task automatic step(logic [NV-1:0] w, logic [NV-1:0] r, logic wr, logic [7:0] d,
                        logic sr, logic [7:0] oth, string tag);
        int v;
        wave_evt = w; ramp_evt = r; fsel_wr = wr; fsel_data = d;
        soft_reset = sr; irq_other = oth;
        @(posedge clk);
        m_cw = 0; m_cr = 0;
        if (wr && d == 8'h8F) begin
            v = lowest(m_wave);
            if (v >= 0) begin
                m_stat = {3'b011, 5'(v)}; m_wave[v] = 1'b0; m_cw = 1; m_idx = 5'(v);
            end else begin
                v = lowest(m_ramp);
                if (v >= 0) begin
                    m_stat = {3'b100, 5'(v)}; m_ramp[v] = 1'b0; m_cr = 1; m_idx = 5'(v);
                end else m_stat = 8'hE8;
            end
        end
        m_wave = sr ? '0 : (m_wave | w);
        m_ramp = sr ? '0 : (m_ramp | r);
        #2;
        check(tag, "status", src_status, m_stat);
        check("R7", "irq_status", irq_status, exp_irq(oth, m_wave, m_ramp));
        check("R8", "irq_line", {7'd0, irq_line}, {7'd0, |exp_irq(oth, m_wave, m_ramp)});
        check("R6", "clr_wave", {7'd0, voice_clr_wave}, {7'd0, m_cw});
        check("R6", "clr_ramp", {7'd0, voice_clr_ramp}, {7'd0, m_cr});
        if (m_cw || m_cr) check("R6", "clr_idx", {3'd0, voice_clr_idx}, {3'd0, m_idx});
    endtask

    task automatic idle(string tag);
        step('0, '0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    endtask

    task automatic deq(string tag);
        step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; soft_reset = 0; fsel_wr = 0; fsel_data = 0;
        wave_evt = '0; ramp_evt = '0; irq_other = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        check("R1", "status", src_status, 8'hE8);
        check("R1", "irq_status", irq_status, 8'h00);
        check("R1", "clr", {6'd0, voice_clr_wave, voice_clr_ramp}, 8'h00);
        deq("R5");                                     // empty queue reads 0xE8

        // R3 R4 R11: all wave voices plus ramp voices 0 and 30, drain in order
        step('1, 31'h4000_0001, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
        for (int i = 0; i < NV; i++) deq("R4");
        deq("R3");
        deq("R3");
        deq("R11");
        check("R11", "drained", src_status, 8'hE8);

        // R2: other codes leave status and pending untouched
        step(31'h0000_0100, '0, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
        step('0, '0, 1'b1, 8'h8E, 1'b0, 8'h00, "R2");
        step('0, '0, 1'b1, 8'h0F, 1'b0, 8'h00, "R2");
        deq("R2");

        // R10: pulse on the same bit as the dequeue keeps it pending
        step('0, 31'h0000_0008, 1'b0, 8'h00, 1'b0, 8'h00, "R10");
        step('0, 31'h0000_0008, 1'b1, 8'h8F, 1'b0, 8'h00, "R10");
        check("R10", "ramp_sum kept", {7'd0, irq_status[6]}, 8'h01);
        deq("R10");
        deq("R10");

        // R9: chip reset wins over coincident pulses
        step(31'h0000_0030, 31'h0000_0002, 1'b0, 8'h00, 1'b0, 8'h00, "R9");
        step(31'h0000_0001, 31'h0000_0001, 1'b0, 8'h00, 1'b1, 8'h00, "R9");
        check("R9", "sums", irq_status, 8'h00);
        deq("R9");

        // R8: external bits alone raise the line, bits 5/6 from outside ignored
        step('0, '0, 1'b0, 8'h00, 1'b0, 8'h60, "R8");
        check("R8", "line off", {7'd0, irq_line}, 8'h00);
        step('0, '0, 1'b0, 8'h00, 1'b0, 8'h04, "R8");
        check("R8", "line on", {7'd0, irq_line}, 8'h01);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [NV-1:0] w, r;
            logic wr;
            logic [7:0] d;
            w = ($urandom_range(0, 3) == 0) ? (NV'(1) << $urandom_range(0, NV - 1)) : '0;
            r = ($urandom_range(0, 3) == 0) ? (NV'(1) << $urandom_range(0, NV - 1)) : '0;
            wr = ($urandom_range(0, 2) == 0);
            d = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 255)) : 8'h8F;
            step(w, r, wr, d, ($urandom_range(0, 199) == 0), 8'($urandom_range(0, 3)), "R4");
        end
        for (int k = 0; k < 70; k++) deq("R11");
        check("R11", "final", src_status, 8'hE8);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule